// File: doc/BRIEF.md
# Row-Multiplexed Probe Array Sequencer

This block sequences a square grid of thermal read/write probes that share row and column lines. One row line is enabled at a time, and all column lines of that row are driven or sensed together. A host sends a command that names a row and a direction, write or read. The block then runs one line scan of a fixed number of scan positions over that row. At each position it does one of two things. For a write, it takes one word from the host and heats the probes whose word bit is 1 for a timed pulse. For a read, it enables the row at the read level, samples one comparator bit per column and returns the word to the host. After each position it asks the scan stage to advance and waits for the answer.

Word bit c belongs to column c, so each 32-bit word is spread one bit per probe across the row. Pulse and sense lengths are given in nanoseconds and turned into clock cycles from a clock-rate parameter. A rate parameter sets the shortest time allowed between the starts of two positions, so the probe heaters are never switched faster than their thermal time constant allows. The analog drivers, the sense amplifiers and the scanner are outside the block. They appear only as digital enables, comparator bits and a request/acknowledge pair.

Top module: `probe_row_seq`

## Requirements
- R1: `rowEn` never has more than one bit set. When a bit is set, it is bit r, where r is the row of the command being executed (bit r selects row r).
- R2: In a write scan, each position takes exactly one word from the word stream. The row is then enabled with `modeWrite` = 1 and `colDrive` bit c equal to word bit c for exactly WRITE_CYC = CLK_KHZ*WRITE_NS/10^6 cycles.
- R3: In a read scan, each position enables the row with `modeWrite` = 0 and `colDrive` all zero for READ_CYC = CLK_KHZ*READ_NS/10^6 cycles. `senseBits` is captured only in the last of those cycles, and result bit c equals the captured bit c (1 means the probe cooled, i.e. sits in a pit). `senseBits` values in all other cycles have no effect.
- R4: Between two active windows there is at least one cycle in which `rowEn` and `colDrive` are all zero. `colDrive` is zero whenever `rowEn` is zero, and the enabled row never changes to another row directly.
- R5: After every position, including the last one, `stepReq` rises. It stays high, with the row disabled, until a cycle in which `stepAck` is high and the rate limit of R6 is met.
- R6: Within one line scan, consecutive row activations start at least MIN_PERIOD = CLK_KHZ/MAX_MUX_KHZ cycles apart.
- R7: `cmdReady` is high only while the block is idle, so a command offered while busy is not taken. `wordReady` is high only while the block waits for a write word. Once `rdValid` is high, it and `rdData` stay unchanged until `rdReady` is high.
- R8: `busy` goes high in the cycle after a command is accepted. It goes low in the cycle after the final step handshake of the scan completes.
- R9: Each command runs exactly POSITIONS positions in order. Write words are applied, and read results are returned, in scan-position order.
- R10: After reset, all row, column, mode, step and result-valid outputs are zero, and `cmdReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be accepted (idle) |
| cmdWrite | input | 1 | 1 = write line scan, 0 = read line scan |
| cmdRow | input | $clog2(NUM_ROWS) | Row to scan |
| wordValid | input | 1 | Write word offered |
| wordReady | output | 1 | Write word can be accepted |
| wordData | input | NUM_COLS | Write word, bit c drives column c |
| rdValid | output | 1 | Read result offered |
| rdReady | input | 1 | Host takes the read result |
| rdData | output | NUM_COLS | Read result, bit c from column c |
| busy | output | 1 | Line scan in progress |
| rowEn | output | NUM_ROWS | One-hot row enable |
| modeWrite | output | 1 | 1 = write heating level, 0 = read level (while a row is enabled) |
| colDrive | output | NUM_COLS | Column heat drive during a write pulse |
| senseBits | input | NUM_COLS | Per-column comparator, 1 = cooled (pit) |
| stepReq | output | 1 | Request that the scan stage advance one position |
| stepAck | input | 1 | Scan stage has advanced |

## Verification
The bench aims at three kinds of error.

- Sense sampling: it feeds random noise on `senseBits` in every cycle except the final sense cycle. A design that samples too early, or that holds the sampling register open, returns noise instead of the stored pattern.
- Step timing: it answers `stepReq` after random delays, including immediately. In read scans an immediate answer comes before the rate window has elapsed. A design that advances on the first acknowledge breaks the activation spacing. A design that drops the request before the acknowledge gets a position ahead of the scanner.
- Host streams: it sends the next command while the previous scan is running, and it applies backpressure on the result stream. A design that takes commands while busy, or changes `rdData` under backpressure, disagrees with the per-cycle model. A pulse that is one cycle short or long also disagrees with the model, and so does a missing dead cycle between positions.

// File: rtl/probe_seq_pkg.sv
package probe_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WORD,
    ST_PULSE,
    ST_SENSE,
    ST_RESULT,
    ST_GAP,
    ST_STEP
  } seqStateT;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCmd;   // latch row and direction, clear position
    logic loadWord;  // latch the write word
    logic armWrite;  // start pulse timer and rate window
    logic armRead;   // start sense timer and rate window
    logic capture;   // sample the comparator bits
    logic driveOn;   // row line enabled this cycle
    logic posInc;    // advance scan position
  } seqStrobeT;

  // status returned by the datapath
  typedef struct packed {
    logic timerZero;
    logic periodOk;
    logic lastPos;
    logic isWrite;
  } seqFlagT;

endpackage

// File: rtl/probe_seq_ctrl.sv
module probe_seq_ctrl
  import probe_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic       wordValid,
  input  logic       rdReady,
  input  logic       stepAck,
  input  seqFlagT    flags,
  output seqStrobeT  stb,
  output logic       cmdReady,
  output logic       wordReady,
  output logic       rdValid,
  output logic       stepReq,
  output logic       busy
);

  seqStateT state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.loadCmd = 1'b1;
          if (cmdWrite) begin
            nxt = ST_WORD;
          end else begin
            stb.armRead = 1'b1;
            nxt = ST_SENSE;
          end
        end
      end
      ST_WORD: begin
        if (wordValid) begin
          stb.loadWord = 1'b1;
          stb.armWrite = 1'b1;
          nxt = ST_PULSE;
        end
      end
      ST_PULSE: begin
        stb.driveOn = 1'b1;
        if (flags.timerZero) nxt = ST_GAP;
      end
      ST_SENSE: begin
        stb.driveOn = 1'b1;
        if (flags.timerZero) begin
          stb.capture = 1'b1;
          nxt = ST_RESULT;
        end
      end
      ST_RESULT: begin
        if (rdReady) nxt = ST_GAP;
      end
      ST_GAP: nxt = ST_STEP;
      ST_STEP: begin
        if (stepAck && flags.periodOk) begin
          if (flags.lastPos) begin
            nxt = ST_IDLE;
          end else begin
            stb.posInc = 1'b1;
            if (flags.isWrite) begin
              nxt = ST_WORD;
            end else begin
              stb.armRead = 1'b1;
              nxt = ST_SENSE;
            end
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cmdReady  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign wordReady = (state == ST_WORD);
  assign rdValid   = (state == ST_RESULT);
  assign stepReq   = (state == ST_STEP);

endmodule

// File: rtl/probe_seq_dp.sv
module probe_seq_dp
  import probe_seq_pkg::*;
#(
  parameter int NUM_ROWS   = 32,
  parameter int NUM_COLS   = 32,
  parameter int POSITIONS  = 64,
  parameter int WRITE_CYC  = 2500,
  parameter int READ_CYC   = 250,
  parameter int MIN_PERIOD = 1250
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  seqStrobeT                    stb,
  input  logic                         cmdWrite,
  input  logic [$clog2(NUM_ROWS)-1:0]  cmdRow,
  input  logic [NUM_COLS-1:0]          wordData,
  input  logic [NUM_COLS-1:0]          senseBits,
  output seqFlagT                      flags,
  output logic [NUM_ROWS-1:0]          rowEn,
  output logic                         modeWrite,
  output logic [NUM_COLS-1:0]          colDrive,
  output logic [NUM_COLS-1:0]          rdData
);

  localparam int ROW_W   = $clog2(NUM_ROWS);
  localparam int POS_W   = (POSITIONS > 1) ? $clog2(POSITIONS) : 1;
  localparam int TMR_MAX = (WRITE_CYC > READ_CYC) ? WRITE_CYC : READ_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PER_LIM = (MIN_PERIOD > 1) ? MIN_PERIOD - 1 : 0;
  localparam int PER_W   = $clog2(PER_LIM + 2);

  logic [ROW_W-1:0]    rowIdx;
  logic                isWrite;
  logic [POS_W-1:0]    posCnt;
  logic [TMR_W-1:0]    phaseTmr;
  logic [PER_W-1:0]    periodCnt;
  logic [NUM_COLS-1:0] dataReg;   // write word or captured sense word

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowIdx  <= '0;
      isWrite <= 1'b0;
      posCnt  <= '0;
    end else if (stb.loadCmd) begin
      rowIdx  <= cmdRow;
      isWrite <= cmdWrite;
      posCnt  <= '0;
    end else if (stb.posInc) begin
      posCnt  <= posCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dataReg <= '0;
    else if (stb.loadWord)  dataReg <= wordData;
    else if (stb.capture)   dataReg <= senseBits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phaseTmr <= '0;
    else if (stb.armWrite)      phaseTmr <= TMR_W'(WRITE_CYC - 1);
    else if (stb.armRead)       phaseTmr <= TMR_W'(READ_CYC - 1);
    else if (phaseTmr != '0)    phaseTmr <= phaseTmr - 1'b1;
  end

  // cycles since the current activation started, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             periodCnt <= '0;
    else if (stb.armWrite || stb.armRead)   periodCnt <= '0;
    else if (periodCnt < PER_W'(PER_LIM))   periodCnt <= periodCnt + 1'b1;
  end

  assign flags.timerZero = (phaseTmr == '0);
  assign flags.periodOk  = (periodCnt >= PER_W'(PER_LIM));
  assign flags.lastPos   = (posCnt == POS_W'(POSITIONS - 1));
  assign flags.isWrite   = isWrite;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign rowEn[r] = stb.driveOn && (rowIdx == ROW_W'(r));
  end

  assign modeWrite = stb.driveOn && isWrite;
  assign colDrive  = modeWrite ? dataReg : '0;
  assign rdData    = dataReg;

endmodule

// File: rtl/probe_row_seq.sv
module probe_row_seq
  import probe_seq_pkg::*;
#(
  parameter int NUM_ROWS    = 32,
  parameter int NUM_COLS    = 32,
  parameter int POSITIONS   = 64,
  parameter int CLK_KHZ     = 125000,
  parameter int WRITE_NS    = 20000,
  parameter int READ_NS     = 2000,
  parameter int MAX_MUX_KHZ = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic                         cmdWrite,
  input  logic [$clog2(NUM_ROWS)-1:0]  cmdRow,
  input  logic                         wordValid,
  output logic                         wordReady,
  input  logic [NUM_COLS-1:0]          wordData,
  output logic                         rdValid,
  input  logic                         rdReady,
  output logic [NUM_COLS-1:0]          rdData,
  output logic                         busy,
  output logic [NUM_ROWS-1:0]          rowEn,
  output logic                         modeWrite,
  output logic [NUM_COLS-1:0]          colDrive,
  input  logic [NUM_COLS-1:0]          senseBits,
  output logic                         stepReq,
  input  logic                         stepAck
);

  localparam longint WR_RAW     = (longint'(CLK_KHZ) * WRITE_NS) / 1000000;
  localparam longint RD_RAW     = (longint'(CLK_KHZ) * READ_NS) / 1000000;
  localparam int     WRITE_CYC  = (WR_RAW > 0) ? int'(WR_RAW) : 1;
  localparam int     READ_CYC   = (RD_RAW > 0) ? int'(RD_RAW) : 1;
  localparam int     MIN_PERIOD = (CLK_KHZ / MAX_MUX_KHZ > 0) ? CLK_KHZ / MAX_MUX_KHZ : 1;

  seqStrobeT stb;
  seqFlagT   flags;

  probe_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .cmdWrite  (cmdWrite),
    .wordValid (wordValid),
    .rdReady   (rdReady),
    .stepAck   (stepAck),
    .flags     (flags),
    .stb       (stb),
    .cmdReady  (cmdReady),
    .wordReady (wordReady),
    .rdValid   (rdValid),
    .stepReq   (stepReq),
    .busy      (busy)
  );

  probe_seq_dp #(
    .NUM_ROWS   (NUM_ROWS),
    .NUM_COLS   (NUM_COLS),
    .POSITIONS  (POSITIONS),
    .WRITE_CYC  (WRITE_CYC),
    .READ_CYC   (READ_CYC),
    .MIN_PERIOD (MIN_PERIOD)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .cmdWrite  (cmdWrite),
    .cmdRow    (cmdRow),
    .wordData  (wordData),
    .senseBits (senseBits),
    .flags     (flags),
    .rowEn     (rowEn),
    .modeWrite (modeWrite),
    .colDrive  (colDrive),
    .rdData    (rdData)
  );

endmodule

// File: rtl/probe_row_seq_chk.sv
module probe_row_seq_chk #(
  parameter int NUM_ROWS    = 32,
  parameter int NUM_COLS    = 32,
  parameter int CLK_KHZ     = 125000,
  parameter int MAX_MUX_KHZ = 100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic                rdValid,
  input logic                rdReady,
  input logic [NUM_COLS-1:0] rdData,
  input logic                busy,
  input logic [NUM_ROWS-1:0] rowEn,
  input logic                modeWrite,
  input logic [NUM_COLS-1:0] colDrive,
  input logic                stepReq,
  input logic                stepAck
);

  localparam int MIN_PERIOD = (CLK_KHZ / MAX_MUX_KHZ > 0) ? CLK_KHZ / MAX_MUX_KHZ : 1;

  logic prevAny;
  logic lineOpen;
  int   sinceStart;
  logic startNow;

  assign startNow = (|rowEn) && !prevAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevAny    <= 1'b0;
      lineOpen   <= 1'b0;
      sinceStart <= 0;
    end else begin
      prevAny <= |rowEn;
      if (!busy)         lineOpen <= 1'b0;
      else if (startNow) lineOpen <= 1'b1;
      if (startNow)                    sinceStart <= 1;
      else if (sinceStart < MIN_PERIOD) sinceStart <= sinceStart + 1;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowEn));

  p_read_nodrive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rowEn) && !modeWrite) |-> (colDrive == '0));

  p_coloff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rowEn == '0) |-> (colDrive == '0));

  p_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rowEn) && (rowEn != $past(rowEn))) |-> ($past(rowEn) == '0));

  p_step_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stepReq |-> (rowEn == '0));

  p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReq && !stepAck) |=> stepReq);

  p_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (startNow && lineOpen) |-> (sinceStart >= MIN_PERIOD));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  p_cmd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmdReady);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdReady) |=> busy);

endmodule

bind probe_row_seq probe_row_seq_chk #(
  .NUM_ROWS    (NUM_ROWS),
  .NUM_COLS    (NUM_COLS),
  .CLK_KHZ     (CLK_KHZ),
  .MAX_MUX_KHZ (MAX_MUX_KHZ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .rdValid   (rdValid),
  .rdReady   (rdReady),
  .rdData    (rdData),
  .busy      (busy),
  .rowEn     (rowEn),
  .modeWrite (modeWrite),
  .colDrive  (colDrive),
  .stepReq   (stepReq),
  .stepAck   (stepAck)
);

// File: tb/probe_row_seq_tb.sv
module probe_row_seq_tb;

  localparam int NR   = 32;
  localparam int NC   = 32;
  localparam int POS  = 8;
  localparam int CKHZ = 1000;
  localparam int WR   = 20;   // 1000 kHz * 20000 ns
  localparam int RD   = 3;    // 1000 kHz * 3000 ns
  localparam int MINP = 10;   // 1000 kHz / 100 kHz

  localparam int P_IDLE = 0, P_WW = 1, P_PU = 2, P_SE = 3, P_RS = 4, P_GAP = 5, P_ST = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [4:0]    cmdRow = '0;
  logic          cmdReady, wordReady, rdValid, busy, modeWrite, stepReq;
  logic          wordValid = 1'b0, rdReady = 1'b0, stepAck = 1'b0;
  logic [NC-1:0] wordData = '0, rdData, colDrive, senseBits;
  logic [NR-1:0] rowEn;

  always #4 clk = ~clk;

  probe_row_seq #(
    .NUM_ROWS(NR), .NUM_COLS(NC), .POSITIONS(POS), .CLK_KHZ(CKHZ),
    .WRITE_NS(20000), .READ_NS(3000), .MAX_MUX_KHZ(100)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdRow(cmdRow), .wordValid(wordValid),
    .wordReady(wordReady), .wordData(wordData), .rdValid(rdValid),
    .rdReady(rdReady), .rdData(rdData), .busy(busy), .rowEn(rowEn),
    .modeWrite(modeWrite), .colDrive(colDrive), .senseBits(senseBits),
    .stepReq(stepReq), .stepAck(stepAck)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [NC-1:0] pattern(input int r, input int p);
    if (p % 2 == 1) return '0;   // odd scan positions carry zero
    return (32'h9E37_79B9 * (r * POS + p + 1)) ^ (32'h1 << ((r + p) % 32));
  endfunction

  // scanned medium and comparator noise
  logic [NC-1:0] media [NR*POS];
  logic [NC-1:0] noise = '0;

  // behavioural reference model
  int mPhase = P_IDLE, mRow = 0, mPos = 0, mTmr = 0, mSince = 0;
  bit mWr = 0;
  logic [NC-1:0] mData = '0, mSense = '0;

  assign senseBits = (mPhase == P_SE && mTmr == 1) ? media[mRow*POS + mPos] : noise;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mPhase <= P_IDLE; mSince <= 0;
    end else begin
      if (mSince < 1000000) mSince <= mSince + 1;
      case (mPhase)
        P_IDLE: if (cmdValid) begin
          mRow <= int'(cmdRow); mWr <= cmdWrite; mPos <= 0;
          if (cmdWrite) mPhase <= P_WW;
          else begin mPhase <= P_SE; mTmr <= RD; mSince <= 0; end
        end
        P_WW: if (wordValid) begin
          mData <= wordData; mPhase <= P_PU; mTmr <= WR; mSince <= 0;
        end
        P_PU: if (mTmr == 1) mPhase <= P_GAP; else mTmr <= mTmr - 1;
        P_SE: if (mTmr == 1) begin mSense <= senseBits; mPhase <= P_RS; end
              else mTmr <= mTmr - 1;
        P_RS: if (rdReady) mPhase <= P_GAP;
        P_GAP: mPhase <= P_ST;
        P_ST: if (stepAck && (mSince + 1 >= MINP)) begin
          if (mPos == POS - 1) mPhase <= P_IDLE;
          else begin
            mPos <= mPos + 1;
            if (mWr) mPhase <= P_WW;
            else begin mPhase <= P_SE; mTmr <= RD; mSince <= 0; end
          end
        end
        default: mPhase <= P_IDLE;
      endcase
    end
  end

  // per-cycle comparison plus independent observations
  bit prevAny = 0, prevBusy = 0, lineStarted = 0;
  int lastStart = 0, acts = 0, rdIdx = 0;

  always @(negedge clk) begin
    noise <= $urandom;
    if (rst_n) begin
      logic act;
      act = (mPhase == P_PU) || (mPhase == P_SE);
      check(rowEn == (act ? (32'h1 << mRow) : 32'h0), "R1", "rowEn", rowEn, act ? (32'h1 << mRow) : 32'h0);
      check(modeWrite == (mPhase == P_PU), "R2", "modeWrite", {31'b0, modeWrite}, {31'b0, mPhase == P_PU});
      check(colDrive == ((mPhase == P_PU) ? mData : '0), "R2/R4", "colDrive", colDrive, (mPhase == P_PU) ? mData : '0);
      check(stepReq == (mPhase == P_ST), "R5", "stepReq", {31'b0, stepReq}, {31'b0, mPhase == P_ST});
      check(cmdReady == (mPhase == P_IDLE), "R7", "cmdReady", {31'b0, cmdReady}, {31'b0, mPhase == P_IDLE});
      check(wordReady == (mPhase == P_WW), "R7", "wordReady", {31'b0, wordReady}, {31'b0, mPhase == P_WW});
      check(rdValid == (mPhase == P_RS), "R7", "rdValid", {31'b0, rdValid}, {31'b0, mPhase == P_RS});
      check(busy == (mPhase != P_IDLE), "R8", "busy", {31'b0, busy}, {31'b0, mPhase != P_IDLE});
      if (rdValid && mPhase == P_RS)
        check(rdData == mSense, "R3", "rdData vs sampled sense", rdData, mSense);
      // medium records heated columns
      if ((|rowEn) && modeWrite) media[mRow*POS + mPos] = colDrive;
      // end to end: read word equals the written pattern
      if (rdValid && rdReady) begin
        check(rdData == pattern(rdIdx / POS, rdIdx % POS), "R9", "read-back word",
              rdData, pattern(rdIdx / POS, rdIdx % POS));
        rdIdx++;
      end
      // activation spacing and count
      if ((|rowEn) && !prevAny) begin
        if (busy && lineStarted)
          check(cyc - lastStart >= MINP, "R6", "activation spacing", NC'(cyc - lastStart), NC'(MINP));
        lastStart = cyc; lineStarted = 1; acts++;
      end
      if (!busy) lineStarted = 0;
      if (prevBusy && !busy) begin
        check(acts == POS, "R9", "positions per scan", NC'(acts), NC'(POS));
        acts = 0;
      end
      prevAny = |rowEn;
      prevBusy = busy;
    end
  end

  // scan stage responder and result backpressure
  int ackWait = 0;
  always @(posedge clk) begin
    #2;
    rdReady = ($urandom_range(0, 3) != 0);
    if (stepAck) stepAck = 1'b0;
    else if (stepReq) begin
      if (ackWait == 0) begin stepAck = 1'b1; ackWait = $urandom_range(0, 3); end
      else ackWait--;
    end
  end

  // write word source
  logic [NC-1:0] wordQ[$];
  initial begin
    forever begin
      @(posedge clk); #2;
      if (wordQ.size() > 0 && $urandom_range(0, 2) != 0) begin
        wordValid = 1'b1; wordData = wordQ[0];
        do @(negedge clk); while (!wordReady);
        @(posedge clk); #2;
        void'(wordQ.pop_front());
        wordValid = 1'b0; wordData = $urandom;
      end
    end
  end

  task automatic sendCmd(input bit wr, input int row);
    cmdValid = 1'b1; cmdWrite = wr; cmdRow = 5'(row);
    do @(negedge clk); while (!cmdReady);
    @(posedge clk); #2;
    cmdValid = 1'b0; cmdWrite = $urandom; cmdRow = 5'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(rowEn == '0 && colDrive == '0 && !modeWrite, "R10", "array lines in reset", rowEn, '0);
    check(!stepReq && !rdValid && !busy && cmdReady, "R10", "handshakes in reset",
          {28'b0, stepReq, rdValid, busy, cmdReady}, 32'h1);
    @(posedge clk); #2; rst_n = 1'b1;
    for (int r = 0; r < NR; r++) begin
      for (int p = 0; p < POS; p++) wordQ.push_back(pattern(r, p));
      sendCmd(1'b1, r);
      sendCmd(1'b0, r);   // offered while the write scan is still busy
    end
    do @(negedge clk); while (busy);
    repeat (5) @(negedge clk);
    check(rdIdx == NR * POS, "R9", "total read results", NC'(rdIdx), NC'(NR * POS));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, R9 scans incomplete actual=%0d expected=%0d", rdIdx, NR * POS);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule